// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block raises a periodic interrupt at one of six power-of-two rates. The rates come from tap inputs of an external 32.768 kHz divider chain. A 3-bit rate code in the control register picks one tap. Each rising edge on the picked tap sets a sticky pending flag. The periodic interrupt is asserted while the flag is set and a valid rate is selected. Software clears the flag by writing 0 to the flag bit. Writing 1 to that bit leaves the flag unchanged.

The block also combines the periodic request with two requests that enter from outside: a carry request and an alarm request. A parameter decides how they leave the block. They can drive three separate interrupt lines, or they can be ORed onto one shared line.

The pending flag is a two-state machine:
- `FLAG_IDLE` (nothing pending) moves to `FLAG_RAISED` on a period event.
- `FLAG_RAISED` moves back to `FLAG_IDLE` on a clear write, unless a period event arrives in the same cycle.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the control register reads 0x00. In separate mode all interrupt outputs are low while the carry and alarm requests are low.
- R2: A write stores the rate code in bits 6:4, and those bits read back unchanged. Bits 3:0 always read 0.
- R3: Rate codes 1, 2, 3, 4, 5 and 6 select tap inputs 0 to 5, which carry 256, 64, 16, 4, 2 and 1 Hz. A rising edge on the selected tap sets the flag in bit 7, and the flag is visible after the clock edge that samples the tap high. Edges on taps that are not selected have no effect. A tap that is already high when it becomes selected does not count as an edge.
- R4: Rate codes 0 and 7 disable the periodic interrupt. No tap edge sets the flag, and the periodic interrupt stays low even when the flag is already set.
- R5: The flag is sticky. It stays set across further tap edges and across writes that have bit 7 at 1.
- R6: A write with bit 7 at 0 clears the flag.
- R7: When a period event and a clearing write occur in the same cycle, the flag ends up set.
- R8: The periodic interrupt equals the flag ANDed with a valid rate code (1 to 6).
- R9: In separate mode (SHARED_IRQ=0), irq_o bit 0 is the periodic interrupt, bit 1 is the carry request and bit 2 is the alarm request. These are combinational paths.
- R10: In shared mode (SHARED_IRQ=1), irq_o is one bit. It is the OR of the periodic interrupt, the carry request and the alarm request.
- R11: A selected tap that stays high produces only one event. After a clear, the flag does not set again until the tap falls and rises once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_i | input | N_TAPS | Divider-chain taps; bit 0 is the fastest rate |
| cr_wr_i | input | 1 | Control register write strobe |
| cr_wdata_i | input | 8 | Control register write data |
| cr_rdata_o | output | 8 | Control register contents: flag in bit 7, rate code in bits 6:4 |
| carry_req_i | input | 1 | Carry interrupt request |
| alarm_req_i | input | 1 | Alarm interrupt request |
| irq_o | output | IRQ_W | Interrupt outputs: 3 lines in separate mode, 1 line in shared mode |

## Verification
The bench builds two instances side by side from the same stimulus. One uses SHARED_IRQ=0 and the other SHARED_IRQ=1, both with the default six taps. This lets every check on the periodic path be compared against both merge variants, and it reaches all eight rate codes, including the reserved code. The directed tests cover three corner cases:
- A set event and a clear write arriving in the same cycle.
- A tap held high across a clear.
- A tap that is already high when it is selected.

They also cover a flag left pending while the rate is switched off.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int CR_W     = 8;
    localparam int SEL_W    = 3;
    localparam int SEL_LSB  = 4;
    localparam int FLAG_POS = SEL_LSB + SEL_W;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/pirq_tap_select.sv
module pirq_tap_select #(
    parameter int N_TAPS = 6,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] tap_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              tick_o,
    output logic              active_o
);
    logic [N_TAPS-1:0] tap_q;
    logic [N_TAPS-1:0] rise;

    // Every tap keeps its own history, so a change of selection cannot
    // produce an edge that never happened on the newly chosen tap.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= '0;
        else        tap_q <= tap_i;
    end

    for (genvar g = 0; g < N_TAPS; g++) begin : g_rise
        assign rise[g] = tap_i[g] & ~tap_q[g];
    end

    always_comb begin
        tick_o   = 1'b0;
        active_o = 1'b0;
        for (int i = 0; i < N_TAPS; i++) begin
            if (sel_i == SEL_W'(i + 1)) begin
                tick_o   = rise[i];
                active_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pirq_flag_fsm.sv
module pirq_flag_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (tick_i)           state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_i && !tick_i) state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FLAG_RAISED);
    end
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge #(
    parameter bit SHARED_IRQ = 1'b0,
    parameter int IRQ_W      = 3
) (
    input  logic             per_req_i,
    input  logic             carry_req_i,
    input  logic             alarm_req_i,
    output logic [IRQ_W-1:0] irq_o
);
    if (SHARED_IRQ) begin : g_shared
        assign irq_o = IRQ_W'(per_req_i | carry_req_i | alarm_req_i);
    end else begin : g_split
        assign irq_o = IRQ_W'({alarm_req_i, carry_req_i, per_req_i});
    end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pirq_pkg::*;
#(
    parameter int  N_TAPS     = 6,
    parameter bit  SHARED_IRQ = 1'b0,
    localparam int IRQ_W      = SHARED_IRQ ? 1 : 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TAPS-1:0] tap_i,
    input  logic              cr_wr_i,
    input  logic [CR_W-1:0]   cr_wdata_i,
    output logic [CR_W-1:0]   cr_rdata_o,
    input  logic              carry_req_i,
    input  logic              alarm_req_i,
    output logic [IRQ_W-1:0]  irq_o
);
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic             active;
    logic             flag;
    logic             clr;
    logic             per_req;
    logic             wdata_unused;

    assign wdata_unused = ^cr_wdata_i[SEL_LSB-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (cr_wr_i) sel_q <= cr_wdata_i[SEL_LSB +: SEL_W];
    end

    assign clr = cr_wr_i & ~cr_wdata_i[FLAG_POS];

    pirq_tap_select #(.N_TAPS(N_TAPS), .SEL_W(SEL_W)) u_tap_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_i    (tap_i),
        .sel_i    (sel_q),
        .tick_o   (tick),
        .active_o (active)
    );

    pirq_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .clr_i  (clr),
        .flag_o (flag)
    );

    assign per_req = flag & active;

    pirq_merge #(.SHARED_IRQ(SHARED_IRQ), .IRQ_W(IRQ_W)) u_merge (
        .per_req_i   (per_req),
        .carry_req_i (carry_req_i),
        .alarm_req_i (alarm_req_i),
        .irq_o       (irq_o)
    );

    always_comb begin
        cr_rdata_o                    = '0;
        cr_rdata_o[FLAG_POS]          = flag;
        cr_rdata_o[SEL_LSB +: SEL_W]  = sel_q;
    end
endmodule

// File: rtl/periodic_irq_chk.sv
module periodic_irq_chk
    import pirq_pkg::*;
#(
    parameter int N_TAPS     = 6,
    parameter bit SHARED_IRQ = 1'b0,
    parameter int IRQ_W      = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cr_wr_i,
    input logic [CR_W-1:0]  cr_wdata_i,
    input logic [CR_W-1:0]  cr_rdata_o,
    input logic             carry_req_i,
    input logic             alarm_req_i,
    input logic [IRQ_W-1:0] irq_o,
    input logic             tick_i
);
    logic [SEL_W-1:0] sel;
    logic             sel_ok;
    logic             flag;
    logic             clr_wr;

    assign sel    = cr_rdata_o[SEL_LSB +: SEL_W];
    assign sel_ok = (sel != '0) && (int'(sel) <= N_TAPS);
    assign flag   = cr_rdata_o[FLAG_POS];
    assign clr_wr = cr_wr_i && !cr_wdata_i[FLAG_POS];

    AST_RISE_NEEDS_RATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(sel_ok)); // R3
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !sel_ok |-> (irq_o[0] == (SHARED_IRQ ? (carry_req_i | alarm_req_i) : 1'b0))); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr_wr) |=> flag); // R5
    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (clr_wr && !tick_i) |=> !flag); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) tick_i |=> flag); // R7

    if (SHARED_IRQ) begin : g_shared_chk
        AST_SHARED_OR: assert property (@(posedge clk) disable iff (!rst_n) (carry_req_i || alarm_req_i) |-> irq_o[0]); // R10
    end else begin : g_split_chk
        AST_SIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (irq_o[1] == carry_req_i) && (irq_o[2] == alarm_req_i)); // R9
    end
endmodule

bind periodic_irq_gen periodic_irq_chk #(
    .N_TAPS     (N_TAPS),
    .SHARED_IRQ (SHARED_IRQ),
    .IRQ_W      (IRQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cr_wr_i     (cr_wr_i),
    .cr_wdata_i  (cr_wdata_i),
    .cr_rdata_o  (cr_rdata_o),
    .carry_req_i (carry_req_i),
    .alarm_req_i (alarm_req_i),
    .irq_o       (irq_o),
    .tick_i      (tick)
);

// File: tb/test_periodic_irq_gen.sv
`timescale 1ns/1ps
module test_periodic_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] taps = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       carry = 1'b0;
    logic       alarm = 1'b0;
    logic [7:0] rdata_a, rdata_b;
    logic [2:0] irq_a;
    logic [0:0] irq_b;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    periodic_irq_gen #(.N_TAPS(6), .SHARED_IRQ(1'b0)) i_periodic_irq_gen (
        .clk(clk), .rst_n(rst_n), .tap_i(taps), .cr_wr_i(wr), .cr_wdata_i(wdata),
        .cr_rdata_o(rdata_a), .carry_req_i(carry), .alarm_req_i(alarm), .irq_o(irq_a));

    periodic_irq_gen #(.N_TAPS(6), .SHARED_IRQ(1'b1)) i_periodic_irq_gen_shared (
        .clk(clk), .rst_n(rst_n), .tap_i(taps), .cr_wr_i(wr), .cr_wdata_i(wdata),
        .cr_rdata_o(rdata_b), .carry_req_i(carry), .alarm_req_i(alarm), .irq_o(irq_b));

    // {code[5:3], tap index[2:0]}; index 7 means no tap may set the flag
    localparam logic [5:0] VEC [0:7] = '{
        {3'd0, 3'd7}, {3'd1, 3'd0}, {3'd2, 3'd1}, {3'd3, 3'd2},
        {3'd4, 3'd3}, {3'd5, 3'd4}, {3'd6, 3'd5}, {3'd7, 3'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] d);
        wr = 1'b1;
        wdata = d;
        cyc();
        wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        chk("R1 reg a", int'(rdata_a), 0);
        chk("R1 reg b", int'(rdata_b), 0);
        chk("R1 irq a", int'(irq_a), 0);
        chk("R1 irq b", int'(irq_b), 0);

        for (int v = 0; v < 8; v++) begin
            logic [2:0] code;
            logic [2:0] idx;
            code = VEC[v][5:3];
            idx  = VEC[v][2:0];
            wr_reg({1'b0, code, 4'h0});
            chk("R2 readback", int'(rdata_a), int'({1'b0, code, 4'h0}));
            taps = (idx == 3'd7) ? 6'h3f : ~(6'b1 << idx);
            cyc();
            chk("R3/R4 other taps ignored", int'(rdata_a[7]), 0);
            chk("R4 irq low", int'(irq_a[0]), 0);
            taps = '0;
            cyc();
            if (idx != 3'd7) begin
                taps = 6'b1 << idx;
                cyc();
                chk("R3 selected tap sets flag", int'(rdata_a[7]), 1);
                chk("R8 periodic irq", int'(irq_a[0]), 1);
                chk("R10 shared irq", int'(irq_b[0]), 1);
                taps = '0;
                cyc();
            end
        end

        // R5 sticky
        wr_reg(8'h10);
        taps[0] = 1'b1; cyc();
        taps[0] = 1'b0; cyc();
        taps[0] = 1'b1; cyc();
        chk("R5 flag stays", int'(rdata_a[7]), 1);
        taps[0] = 1'b0;
        wr_reg(8'hB0);
        chk("R5 write of 1 keeps flag", int'(rdata_a), 8'hB0);
        chk("R2 low bits zero", int'(rdata_b), 8'hB0);

        // R6 clear
        wr_reg(8'h30);
        chk("R6 clear write", int'(rdata_a), 8'h30);

        // R7 set and clear in same cycle
        taps[2] = 1'b1;
        wr_reg(8'h30);
        chk("R7 set wins", int'(rdata_a), 8'hB0);
        taps = '0;
        cyc();

        // R4 flag pending while rate off
        wr_reg(8'h80);
        chk("R4 code 0 keeps flag", int'(rdata_a), 8'h80);
        chk("R4 code 0 irq low", int'(irq_a), 0);
        chk("R4 code 0 shared low", int'(irq_b), 0);
        wr_reg(8'hF0);
        chk("R4 code 7 irq low", int'(irq_a), 0);
        wr_reg(8'hB0);
        chk("R8 irq back on", int'(irq_a), 1);

        // R11 held tap
        wr_reg(8'h10);
        taps[0] = 1'b1; cyc();
        chk("R11 first edge", int'(rdata_a[7]), 1);
        wr_reg(8'h10);
        repeat (3) cyc();
        chk("R11 held tap no refire", int'(rdata_a[7]), 0);
        taps = '0;

        // R3 tap already high when selected
        taps[1] = 1'b1; cyc();
        wr_reg(8'h20);
        cyc();
        chk("R3 pre-high tap no edge", int'(rdata_a[7]), 0);
        taps = '0;
        cyc();

        // R9 / R10 side requests
        for (int k = 0; k < 4; k++) begin
            carry = k[0];
            alarm = k[1];
            #1;
            chk("R9 split lines", int'(irq_a), int'({k[1], k[0], 1'b0}));
            chk("R10 shared or", int'(irq_b), int'(k != 0));
        end
        carry = 1'b0;
        alarm = 1'b0;
        taps[1] = 1'b1; cyc();
        chk("R9 periodic only", int'(irq_a), 3'b001);
        taps = '0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule